// File: doc/BRIEF.md
# Prioritized D-Channel Arbiter

This block lets many subscriber D-channels on a time-multiplexed serial bus share one HDLC receiver. Each bus frame carries one D-channel bit per subscriber slot. The slot is presented together with its channel number (0..31) and a 3-bit port number. During each bus frame the arbiter watches the channels that are allowed to compete. At the end of the frame it grants the receiver to the lowest-numbered channel that sent a zero. The receiver then sees that channel's bits through a per-slot receive strobe.

After a grant the arbiter waits for the receiver to report either a recognised frame or the end of a frame. A watchdog counts received bytes, where one byte is four bus frames, from a loaded suspend count. If the grant never becomes a frame, the watchdog trips: the arbiter raises an interrupt and suspends itself. If seven ones follow the zero, the zero was a stray bit error and the channel gives up its turn. A channel that finishes a frame also gives up its turn. A channel that has given up its turn stays out of the exclusion mask until every remaining channel has had a turn, and then a fresh priority round begins.

Top module: `dchan_arbiter`

## Requirements
- R1: After reset the state code `statState` is 0 (Suspended), and `rxStrobe`, `irq` and `intFlag` are low. In Suspended, zeros on the bus start no grant. State codes are: 0 Suspended, 1 Full Selection, 2 Expect Frame, 3 Receive Frame, 4 Limited Selection.
- R2: When `clockModeOk` is low, the state becomes 0 on the next clock from any state, and `rxReset` is then ignored.
- R3: A one-cycle `rxReset` while `clockModeOk` is high puts the arbiter in state 1 on the next clock and clears `intFlag`.
- R4: In state 1, a zero (`dBit`=0 with `slotValid`) on a channel whose bit is set in `chanEnable` leads to state 2 at the next `frameTick`. That channel and its port appear on `statChan`/`statPort`. Zeros on disabled channels are ignored.
- R5: When several monitored channels show a zero within one bus frame, the lowest channel number is granted, whatever the order in which the slots arrive.
- R6: `rxStrobe` is high only in states 2 and 3, and only while `slotValid` is high with `slotChan` equal to `statChan`.
- R7: On the grant, the suspend counter loads `suspendCount` and then decrements once every four `frameTick`s. The count goes below zero at `frameTick` number (suspendCount+1)*4 after the grant. If the arbiter is still in state 2 at that point, it goes to state 0, pulses `irq` for one cycle and sets `intFlag`. It stays in state 0 until `rxReset`.
- R8: Seven consecutive ones on the granted channel in state 2 lead to state 4, and that channel is excluded from later selection.
- R9: `frameDetect` in state 2 leads to state 3. The watchdog does not run in state 3.
- R10: `endOfFrame` in state 3 leads to state 4 and excludes the granted channel.
- R11: State 4 monitors only channels set in both the exclusion mask and the live `chanEnable`. Clearing an enable bit takes effect at once, and a zero on a monitored channel leads to state 2.
- R12: When the exclusion mask ANDed with `chanEnable` is all zeros in state 4, the arbiter moves to state 1 on the next clock.
- R13: The exclusion mask is reloaded from `chanEnable` only on a grant made from state 1. A grant from state 4 does not restore excluded channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clockModeOk | input | 1 | Receiver is in the clock mode required for arbitration |
| rxReset | input | 1 | One-cycle receiver reset indication |
| frameDetect | input | 1 | Receiver recognised a frame (pulse) |
| endOfFrame | input | 1 | Receiver reached end of frame (pulse) |
| slotValid | input | 1 | A D-channel bit is present this cycle |
| slotChan | input | 5 | Channel number of the current slot |
| slotPort | input | 3 | Port number of the current slot |
| dBit | input | 1 | D-channel bit of the current slot |
| frameTick | input | 1 | End of one bus frame (pulse) |
| chanEnable | input | 32 | Per-channel enable register |
| suspendCount | input | 8 | Suspend counter load value in bytes |
| rxStrobe | output | 1 | Passes the granted channel's slot to the receiver |
| statChan | output | 5 | Granted channel number |
| statPort | output | 3 | Granted port number |
| statState | output | 3 | Current state code |
| intFlag | output | 1 | Sticky suspend interrupt flag |
| irq | output | 1 | One-cycle suspend interrupt |

## Verification
The checker assumes that `slotValid` and `frameTick` are never high in the same cycle. It also assumes that receiver indications arrive as single-cycle pulses. The bench raises every strobe for exactly one clock and keeps slot cycles and frame-end cycles apart. The strobe property relates `rxStrobe` to the live slot inputs. For that reason the bench changes `slotChan` only away from the clock edge, and it never lets a slot cycle coincide with a state change.

// File: rtl/dchan_arbiter_pkg.sv
package dchan_arbiter_pkg;

  typedef enum logic [2:0] {
    ST_SUSP    = 3'd0,
    ST_FULL    = 3'd1,
    ST_EXPECT  = 3'd2,
    ST_RECV    = 3'd3,
    ST_LIMITED = 3'd4
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic scanOn;    // gather candidates this frame
    logic useSlave;  // AND exclusion mask into monitor set
    logic takeSel;   // latch candidate as granted channel, load watchdog
    logic copyMask;  // refill exclusion mask from enables
    logic clearSel;  // drop granted channel from exclusion mask
    logic countOn;   // watchdog and ones counter active
    logic grantOn;   // receive strobe may be driven
  } ctrlStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic selReady;
    logic onesHit;
    logic underflow;
    logic liveEmpty;
  } dpFlag_t;

endpackage

// File: rtl/dchan_arbiter_ctrl.sv
module dchan_arbiter_ctrl
  import dchan_arbiter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clockModeOk,
  input  logic        rxReset,
  input  logic        frameDetect,
  input  logic        endOfFrame,
  input  dpFlag_t     flags,
  output ctrlStrobe_t strobes,
  output arbState_t   state,
  output logic        irq,
  output logic        intFlag
);

  arbState_t   nextState;
  ctrlStrobe_t s;
  logic        irqNext;

  always_comb begin
    nextState  = state;
    s          = '0;
    irqNext    = 1'b0;
    s.scanOn   = (state == ST_FULL) || (state == ST_LIMITED);
    s.useSlave = (state == ST_LIMITED);
    s.countOn  = (state == ST_EXPECT);
    s.grantOn  = (state == ST_EXPECT) || (state == ST_RECV);
    if (!clockModeOk) begin
      nextState = ST_SUSP;
    end else if (rxReset) begin
      nextState = ST_FULL;
    end else begin
      unique case (state)
        ST_FULL: begin
          if (flags.selReady) begin
            nextState  = ST_EXPECT;
            s.takeSel  = 1'b1;
            s.copyMask = 1'b1;
          end
        end
        ST_EXPECT: begin
          if (flags.underflow) begin
            nextState = ST_SUSP;
            irqNext   = 1'b1;
          end else if (frameDetect) begin
            nextState = ST_RECV;
          end else if (flags.onesHit) begin
            nextState  = ST_LIMITED;
            s.clearSel = 1'b1;
          end
        end
        ST_RECV: begin
          if (endOfFrame) begin
            nextState  = ST_LIMITED;
            s.clearSel = 1'b1;
          end
        end
        ST_LIMITED: begin
          if (flags.selReady) begin
            nextState = ST_EXPECT;
            s.takeSel = 1'b1;
          end else if (flags.liveEmpty) begin
            nextState = ST_FULL;
          end
        end
        default: nextState = ST_SUSP;
      endcase
    end
  end

  assign strobes = s;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SUSP;
      irq     <= 1'b0;
      intFlag <= 1'b0;
    end else begin
      state <= nextState;
      irq   <= irqNext;
      if (irqNext)
        intFlag <= 1'b1;
      else if (rxReset && clockModeOk)
        intFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/dchan_arbiter_dp.sv
module dchan_arbiter_dp
  import dchan_arbiter_pkg::*;
#(
  parameter int NUM_CHAN        = 32,
  parameter int PORT_W          = 3,
  parameter int CNT_W           = 8,
  parameter int FRAMES_PER_BYTE = 4,
  parameter int ONES_LIMIT      = 7,
  localparam int CHAN_W = $clog2(NUM_CHAN),
  localparam int FRM_W  = (FRAMES_PER_BYTE > 1) ? $clog2(FRAMES_PER_BYTE) : 1,
  localparam int ONES_W = $clog2(ONES_LIMIT + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  input  logic                slotValid,
  input  logic [CHAN_W-1:0]   slotChan,
  input  logic [PORT_W-1:0]   slotPort,
  input  logic                dBit,
  input  logic                frameTick,
  input  logic [NUM_CHAN-1:0] chanEnable,
  input  logic [CNT_W-1:0]    suspendCount,
  output dpFlag_t             flags,
  output logic [CHAN_W-1:0]   selChan,
  output logic [PORT_W-1:0]   selPort,
  output logic                rxStrobe
);

  localparam logic [FRM_W-1:0]  FRM_LAST = FRM_W'(FRAMES_PER_BYTE - 1);
  localparam logic [ONES_W-1:0] ONES_PRE = ONES_W'(ONES_LIMIT - 1);

  logic                candValid;
  logic [CHAN_W-1:0]   candChan;
  logic [PORT_W-1:0]   candPort;
  logic [NUM_CHAN-1:0] slaveMask;
  logic [NUM_CHAN-1:0] monMask;
  logic [CNT_W-1:0]    suspCnt;
  logic [FRM_W-1:0]    frameCnt;
  logic [ONES_W-1:0]   onesCnt;
  logic                zeroHit;
  logic                selSlot;
  logic                byteDone;

  assign monMask  = strobes.useSlave ? (slaveMask & chanEnable) : chanEnable;
  assign zeroHit  = strobes.scanOn && slotValid && !dBit && monMask[slotChan];
  assign selSlot  = slotValid && (slotChan == selChan);
  assign byteDone = frameTick && (frameCnt == FRM_LAST);

  assign flags.selReady  = strobes.scanOn && frameTick && candValid;
  assign flags.onesHit   = strobes.countOn && selSlot && dBit && (onesCnt == ONES_PRE);
  assign flags.underflow = strobes.countOn && byteDone && (suspCnt == '0);
  assign flags.liveEmpty = ((slaveMask & chanEnable) == '0);

  assign rxStrobe = strobes.grantOn && selSlot;

  // lowest-numbered zero within the current bus frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candValid <= 1'b0;
      candChan  <= '0;
      candPort  <= '0;
    end else if (!strobes.scanOn || frameTick) begin
      candValid <= 1'b0;
    end else if (zeroHit && (!candValid || (slotChan < candChan))) begin
      candValid <= 1'b1;
      candChan  <= slotChan;
      candPort  <= slotPort;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selChan <= '0;
      selPort <= '0;
    end else if (strobes.takeSel) begin
      selChan <= candChan;
      selPort <= candPort;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slaveMask <= '0;
    end else if (strobes.copyMask) begin
      slaveMask <= chanEnable;
    end else if (strobes.clearSel) begin
      slaveMask[selChan] <= 1'b0;
    end
  end

  // byte-counted suspend watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspCnt  <= '0;
      frameCnt <= '0;
    end else if (strobes.takeSel) begin
      suspCnt  <= suspendCount;
      frameCnt <= '0;
    end else if (strobes.countOn && frameTick) begin
      frameCnt <= byteDone ? '0 : frameCnt + 1'b1;
      if (byteDone && (suspCnt != '0))
        suspCnt <= suspCnt - 1'b1;
    end
  end

  // consecutive ones on the granted channel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesCnt <= '0;
    end else if (strobes.takeSel) begin
      onesCnt <= '0;
    end else if (strobes.countOn && selSlot) begin
      onesCnt <= dBit ? onesCnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/dchan_arbiter.sv
module dchan_arbiter
  import dchan_arbiter_pkg::*;
#(
  parameter int NUM_CHAN        = 32,
  parameter int PORT_W          = 3,
  parameter int CNT_W           = 8,
  parameter int FRAMES_PER_BYTE = 4,
  parameter int ONES_LIMIT      = 7,
  localparam int CHAN_W = $clog2(NUM_CHAN)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                clockModeOk,
  input  logic                rxReset,
  input  logic                frameDetect,
  input  logic                endOfFrame,
  input  logic                slotValid,
  input  logic [CHAN_W-1:0]   slotChan,
  input  logic [PORT_W-1:0]   slotPort,
  input  logic                dBit,
  input  logic                frameTick,
  input  logic [NUM_CHAN-1:0] chanEnable,
  input  logic [CNT_W-1:0]    suspendCount,
  output logic                rxStrobe,
  output logic [CHAN_W-1:0]   statChan,
  output logic [PORT_W-1:0]   statPort,
  output logic [2:0]          statState,
  output logic                intFlag,
  output logic                irq
);

  ctrlStrobe_t strobes;
  dpFlag_t     flags;
  arbState_t   state;

  dchan_arbiter_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clockModeOk (clockModeOk),
    .rxReset     (rxReset),
    .frameDetect (frameDetect),
    .endOfFrame  (endOfFrame),
    .flags       (flags),
    .strobes     (strobes),
    .state       (state),
    .irq         (irq),
    .intFlag     (intFlag)
  );

  dchan_arbiter_dp #(
    .NUM_CHAN        (NUM_CHAN),
    .PORT_W          (PORT_W),
    .CNT_W           (CNT_W),
    .FRAMES_PER_BYTE (FRAMES_PER_BYTE),
    .ONES_LIMIT      (ONES_LIMIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .slotValid    (slotValid),
    .slotChan     (slotChan),
    .slotPort     (slotPort),
    .dBit         (dBit),
    .frameTick    (frameTick),
    .chanEnable   (chanEnable),
    .suspendCount (suspendCount),
    .flags        (flags),
    .selChan      (statChan),
    .selPort      (statPort),
    .rxStrobe     (rxStrobe)
  );

  assign statState = state;

endmodule

// File: rtl/dchan_arbiter_checks.sv
module dchan_arbiter_checks #(
  parameter int CHAN_W = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              clockModeOk,
  input logic              slotValid,
  input logic [CHAN_W-1:0] slotChan,
  input logic              rxStrobe,
  input logic [CHAN_W-1:0] statChan,
  input logic [2:0]        statState,
  input logic              irq,
  input logic              intFlag
);

  assert_irq_in_suspend_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statState == 3'd0) && intFlag);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_mode_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clockModeOk |=> (statState == 3'd0));

  assert_strobe_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> slotValid && (slotChan == statChan)
                 && ((statState == 3'd2) || (statState == 3'd3)));

  assert_state_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    statState <= 3'd4);

endmodule

bind dchan_arbiter dchan_arbiter_checks #(.CHAN_W(CHAN_W)) u_checks (
  .clk         (clk),
  .rstN        (rstN),
  .clockModeOk (clockModeOk),
  .slotValid   (slotValid),
  .slotChan    (slotChan),
  .rxStrobe    (rxStrobe),
  .statChan    (statChan),
  .statState   (statState),
  .irq         (irq),
  .intFlag     (intFlag)
);

// File: tb/dchan_arbiter_test.sv
module dchan_arbiter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clockModeOk = 1'b0;
  logic        rxReset = 1'b0;
  logic        frameDetect = 1'b0;
  logic        endOfFrame = 1'b0;
  logic        slotValid = 1'b0;
  logic [4:0]  slotChan = '0;
  logic [2:0]  slotPort = '0;
  logic        dBit = 1'b1;
  logic        frameTick = 1'b0;
  logic [31:0] chanEnable = '0;
  logic [7:0]  suspendCount = '0;
  logic        rxStrobe;
  logic [4:0]  statChan;
  logic [2:0]  statPort;
  logic [2:0]  statState;
  logic        intFlag;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dchan_arbiter uut (
    .clk(clk), .rstN(rstN), .clockModeOk(clockModeOk), .rxReset(rxReset),
    .frameDetect(frameDetect), .endOfFrame(endOfFrame), .slotValid(slotValid),
    .slotChan(slotChan), .slotPort(slotPort), .dBit(dBit), .frameTick(frameTick),
    .chanEnable(chanEnable), .suspendCount(suspendCount), .rxStrobe(rxStrobe),
    .statChan(statChan), .statPort(statPort), .statState(statState),
    .intFlag(intFlag), .irq(irq)
  );

  // priority vectors: enable mask, first slot, second slot, expected state, expected channel
  localparam int VEC_N = 6;
  localparam logic [31:0] VEC_EN [VEC_N] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4000_0000,
                                             32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_0001};
  localparam logic [4:0]  VEC_A  [VEC_N] = '{5'd7, 5'd2, 5'd2, 5'd4, 5'd31, 5'd16};
  localparam logic [4:0]  VEC_B  [VEC_N] = '{5'd3, 5'd30, 5'd30, 5'd5, 5'd31, 5'd0};
  localparam logic [2:0]  VEC_ST [VEC_N] = '{3'd2, 3'd2, 3'd2, 3'd1, 3'd2, 3'd2};
  localparam logic [4:0]  VEC_CH [VEC_N] = '{5'd3, 5'd2, 5'd30, 5'd0, 5'd31, 5'd0};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(int ch, int b);
    slotValid = 1'b1;
    slotChan  = 5'(ch);
    slotPort  = 3'(ch % 8);
    dBit      = b[0];
    tick();
    slotValid = 1'b0;
    dBit      = 1'b1;
  endtask

  task automatic frame();
    frameTick = 1'b1;
    tick();
    frameTick = 1'b0;
  endtask

  task automatic pulseReset();
    rxReset = 1'b1;
    tick();
    rxReset = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R1 state after reset", statState, 0);
    check("R1 strobe after reset", rxStrobe, 0);
    check("R1 irq/flag after reset", {irq, intFlag}, 0);
    chanEnable = '1;
    slot(1, 0);
    frame();
    check("R1 zero ignored in suspended", statState, 0);

    clockModeOk = 1'b1;
    pulseReset();
    check("R3 receiver reset enters full selection", statState, 1);

    // table walk: R4 enables, R5 lowest channel wins
    for (int i = 0; i < VEC_N; i++) begin
      pulseReset();
      chanEnable = VEC_EN[i];
      slot(VEC_A[i], 0);
      slot(VEC_B[i], 0);
      frame();
      check("R4/R5 vector state", statState, VEC_ST[i]);
      if (VEC_ST[i] == 3'd2) begin
        check("R5 vector channel", statChan, VEC_CH[i]);
        check("R4 vector port", statPort, VEC_CH[i] % 8);
      end
    end

    // exclusion sequence
    pulseReset();
    chanEnable   = (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 20);
    suspendCount = 8'd0;
    slot(5, 0);
    frame();
    check("R4 grant channel 5", statChan, 5);
    slotValid = 1'b1; slotChan = 5'd5; dBit = 1'b1;
    #1;
    check("R6 strobe on granted slot", rxStrobe, 1);
    slotChan = 5'd9;
    #1;
    check("R6 no strobe on other slot", rxStrobe, 0);
    slotValid = 1'b0;
    tick();
    for (int k = 0; k < 6; k++) slot(5, 1);
    check("R8 six ones keep expect", statState, 2);
    slot(5, 1);
    check("R8 seventh one enters limited", statState, 4);
    check("R6 no strobe in limited", rxStrobe, 0);
    slot(5, 0);
    frame();
    check("R8 excluded channel ignored", statState, 4);
    slot(9, 0);
    frame();
    check("R11 limited grants channel 9", statChan, 9);
    frameDetect = 1'b1;
    tick();
    frameDetect = 1'b0;
    check("R9 frame detect enters receive", statState, 3);
    for (int k = 0; k < 12; k++) frame();
    check("R9 watchdog idle in receive", statState, 3);
    slotValid = 1'b1; slotChan = 5'd9;
    #1;
    check("R6 strobe in receive", rxStrobe, 1);
    slotValid = 1'b0;
    endOfFrame = 1'b1;
    tick();
    endOfFrame = 1'b0;
    check("R10 end of frame enters limited", statState, 4);
    slot(9, 0);
    frame();
    check("R10 finished channel excluded", statState, 4);
    slot(5, 0);
    frame();
    check("R13 grant from limited keeps exclusions", statState, 4);
    chanEnable[12] = 1'b0;
    slot(12, 0);
    frame();
    check("R11 live disable immediate", statState, 4);
    slot(20, 0);
    frame();
    check("R11 limited grants channel 20", statChan, 20);
    for (int k = 0; k < 7; k++) slot(20, 1);
    check("R8 channel 20 released", statState, 4);
    tick();
    check("R12 empty mask returns to full", statState, 1);

    // watchdog underflow
    pulseReset();
    chanEnable   = '1;
    suspendCount = 8'd1;
    slot(3, 0);
    frame();
    check("R7 grant before watchdog", statState, 2);
    for (int k = 0; k < 7; k++) frame();
    check("R7 no underflow after 7 frames", statState, 2);
    frame();
    check("R7 underflow suspends", statState, 0);
    check("R7 irq pulse", irq, 1);
    check("R7 sticky flag", intFlag, 1);
    tick();
    check("R7 irq one cycle", irq, 0);
    check("R7 flag stays", intFlag, 1);
    slot(3, 0);
    frame();
    check("R7 stays suspended", statState, 0);
    pulseReset();
    check("R3 reset leaves suspend", statState, 1);
    check("R3 reset clears flag", intFlag, 0);

    // clock mode drop
    slot(4, 0);
    frame();
    check("R2 grant before mode drop", statState, 2);
    clockModeOk = 1'b0;
    tick();
    check("R2 mode drop suspends", statState, 0);
    pulseReset();
    check("R2 reset ignored without mode", statState, 0);
    clockModeOk = 1'b1;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule